// File: doc/BRIEF.md
# Dual-Rate Pseudo-Random Bit Pattern Source

This block produces a pseudo-random bit pattern for exercising a serial link. A 16-bit shift register with Galois-style feedback steps once per core clock. It follows a maximal-length polynomial, so it visits every non-zero state before it repeats. The design reads two bit positions of the register. The second position is taken both in the current step and in the step before it, which models a half-period offset between the two taps. Each of the two output bits is the XOR of the first tap with one phase of the second tap, so every clock delivers a 2-bit word. A downstream serializer or double-data-rate output stage sends bit 0 first, giving twice the register clock in bits per second.

A small control state machine decides whether the register advances or loads a new value. It also tracks whether the delayed copy of the second tap holds a valid value. It has three states:

- ST_IDLE: entered after reset or after a seed load.
- ST_RUN: the register advanced on the last clock.
- ST_HOLD: enable dropped after running.

Its transitions are:

- GO (ST_IDLE or ST_HOLD to ST_RUN on enable).
- PAUSE (ST_RUN to ST_HOLD when enable is low).
- RELOAD (any state to ST_IDLE on a seed load).
- STAY (otherwise).

While the machine is in ST_IDLE, the delayed tap counts as 0.

Top module: `prbs_dual_rate`

## Requirements
- R1: When `en` is 1 and `seed_load` is 0, the register steps on each clock. The next state is `lfsr_q >> 1`, and it is XORed with 0xB400 when the bit shifted out (bit 0) was 1.
- R2: Starting from any non-zero state and advancing every clock, `lfsr_q` returns to its start value after exactly 65535 clocks and is never 0x0000.
- R3: A synchronous `rst` at 1 sets `lfsr_q` to 0xACE1 and treats the delayed tap as 0.
- R4: Tap A is bit 0 of `lfsr_q` and tap B is bit 8. `bits_o[1]` equals A(n) XOR B(n). `bits_o[0]` equals A(n) XOR B(n-1), where n-1 is the state before the last advance. `bits_o[0]` is the bit sent first.
- R5: With `en` at 0 and `seed_load` at 0, `lfsr_q` and `bits_o` keep their values.
- R6: `seed_load` at 1 with a non-zero `seed_val` places `seed_val` into `lfsr_q` on the next clock. Until the next advance, the delayed tap counts as 0, so `bits_o[0]` equals tap A.
- R7: `seed_load` at 1 with `seed_val` equal to 0x0000 places 0xACE1 instead.
- R8: `seed_load` takes priority over `en`. While both are 1, no step happens and the seed is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the register this clock |
| seed_load | input | 1 | Load `seed_val` (or default if zero) |
| seed_val | input | 16 | Seed value |
| bits_o | output | 2 | Output word, bit 0 leaves first |
| lfsr_q | output | 16 | Current register state for monitoring |

## Verification
The checker watches five rules on every clock:

- the register is never zero;
- a step moves the shifted-out bit into the top position;
- a held clock leaves state and word unchanged;
- a load places the given or default seed;
- the first output bit pairs tap A with the previous tap B.

The full 65535-clock period, the exact bit pattern over sequences that mix pauses and loads, and the value after reset can only be shown by the bench's scenarios against its reference model.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    localparam int unsigned PRBS_W          = 16;
    localparam logic [15:0] PRBS_MASK       = 16'hB400;
    localparam logic [15:0] PRBS_SEED       = 16'hACE1;
    localparam int unsigned PRBS_TAP_A      = 0;
    localparam int unsigned PRBS_TAP_B      = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } prbs_st_e;
endpackage

// File: rtl/prbs_ctrl_fsm.sv
module prbs_ctrl_fsm
    import prbs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic seed_load,
    output logic adv,
    output logic load,
    output logic prev_ok
);
    prbs_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (seed_load) begin
            st_d = ST_IDLE;                       // RELOAD
        end else begin
            unique case (st_q)
                ST_IDLE: if (en)  st_d = ST_RUN;  // GO
                ST_RUN:  if (!en) st_d = ST_HOLD; // PAUSE
                ST_HOLD: if (en)  st_d = ST_RUN;  // GO
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    always_comb begin
        load    = seed_load;
        adv     = en && !seed_load;
        prev_ok = (st_q != ST_IDLE);
    end
endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core #(
    parameter int unsigned W    = 16,
    parameter logic [W-1:0] MASK = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         load,
    input  logic [W-1:0] seed_in,
    output logic [W-1:0] state
);
    logic [W-1:0] nxt;
    logic [W-1:0] seed_eff;
    logic [W-1:0] fb_mask;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_fb
            assign fb_mask[gi] = MASK[gi] & state[0];
        end
    endgenerate

    assign nxt      = (state >> 1) ^ fb_mask;
    assign seed_eff = (seed_in == '0) ? SEED : seed_in;

    always_ff @(posedge clk) begin
        if (rst)       state <= SEED;
        else if (load) state <= seed_eff;
        else if (adv)  state <= nxt;
    end
endmodule

// File: rtl/prbs_rate_doubler.sv
module prbs_rate_doubler #(
    parameter int unsigned W     = 16,
    parameter int unsigned TAP_A = 0,
    parameter int unsigned TAP_B = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    input  logic         prev_ok,
    input  logic [W-1:0] state,
    output logic [1:0]   bits
);
    logic tap_b_late;
    logic tap_b_prev;

    always_ff @(posedge clk) begin
        if (rst)      tap_b_late <= 1'b0;
        else if (adv) tap_b_late <= state[TAP_B];
    end

    assign tap_b_prev = prev_ok ? tap_b_late : 1'b0;
    assign bits[0]    = state[TAP_A] ^ tap_b_prev;
    assign bits[1]    = state[TAP_A] ^ state[TAP_B];
endmodule

// File: rtl/prbs_dual_rate.sv
module prbs_dual_rate
    import prbs_pkg::*;
#(
    parameter int unsigned  W     = PRBS_W,
    parameter logic [W-1:0] MASK  = PRBS_MASK,
    parameter logic [W-1:0] SEED  = PRBS_SEED,
    parameter int unsigned  TAP_A = PRBS_TAP_A,
    parameter int unsigned  TAP_B = PRBS_TAP_B
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         seed_load,
    input  logic [W-1:0] seed_val,
    output logic [1:0]   bits_o,
    output logic [W-1:0] lfsr_q
);
    logic adv, load, prev_ok;

    prbs_ctrl_fsm u_fsm (
        .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
        .adv(adv), .load(load), .prev_ok(prev_ok)
    );

    prbs_lfsr_core #(.W(W), .MASK(MASK), .SEED(SEED)) u_core (
        .clk(clk), .rst(rst), .adv(adv), .load(load),
        .seed_in(seed_val), .state(lfsr_q)
    );

    prbs_rate_doubler #(.W(W), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_dbl (
        .clk(clk), .rst(rst), .adv(adv), .prev_ok(prev_ok),
        .state(lfsr_q), .bits(bits_o)
    );
endmodule

// File: rtl/prbs_dual_rate_chk.sv
module prbs_dual_rate_chk #(
    parameter int unsigned  W     = 16,
    parameter logic [W-1:0] SEED  = 16'hACE1,
    parameter int unsigned  TAP_A = 0,
    parameter int unsigned  TAP_B = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         en,
    input logic         seed_load,
    input logic [W-1:0] seed_val,
    input logic [1:0]   bits_o,
    input logic [W-1:0] lfsr_q
);
    p_top_gets_out_r1: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load) |=> (lfsr_q[W-1] == $past(lfsr_q[0])));

    p_never_zero_r2: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0);

    p_early_bit_r4: assert property (@(posedge clk) disable iff (rst)
        (en && !seed_load) |=> (bits_o[0] == (lfsr_q[TAP_A] ^ $past(lfsr_q[TAP_B]))));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!en && !seed_load) |=> ($stable(lfsr_q) && $stable(bits_o)));

    p_seed_r6: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_val != '0) |=> (lfsr_q == $past(seed_val)
                                            && bits_o[0] == lfsr_q[TAP_A]));

    p_zero_seed_r7: assert property (@(posedge clk) disable iff (rst)
        (seed_load && seed_val == '0) |=> (lfsr_q == SEED));
endmodule

bind prbs_dual_rate prbs_dual_rate_chk #(
    .W(W), .SEED(SEED), .TAP_A(TAP_A), .TAP_B(TAP_B)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
    .seed_val(seed_val), .bits_o(bits_o), .lfsr_q(lfsr_q)
);

// File: tb/tb_prbs_dual_rate.sv
module tb_prbs_dual_rate;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;
    // {en, seed_load, seed_val}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 16'h0000}, {1'b1, 1'b0, 16'h0000}, {1'b1, 1'b0, 16'h0000},
        {1'b0, 1'b0, 16'h0000}, {1'b0, 1'b0, 16'h1234}, {1'b1, 1'b0, 16'h0000},
        {1'b0, 1'b1, 16'h8001}, {1'b1, 1'b0, 16'h0000}, {1'b1, 1'b0, 16'h0000},
        {1'b1, 1'b1, 16'h00FF}, {1'b0, 1'b0, 16'h0000}, {1'b1, 1'b0, 16'h0000},
        {1'b1, 1'b1, 16'h0000}, {1'b1, 1'b0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst, en, seed_load;
    logic [15:0] seed_val;
    logic [1:0]  bits_o;
    logic [15:0] lfsr_q;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] m_state;
    logic        m_prevb;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prbs_dual_rate dut (
        .clk(clk), .rst(rst), .en(en), .seed_load(seed_load),
        .seed_val(seed_val), .bits_o(bits_o), .lfsr_q(lfsr_q)
    );

    function automatic logic [15:0] step(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // advance one clock and update the reference model with the applied inputs
    task automatic tick();
        @(posedge clk);
        #1;
        if (rst) begin
            m_state = 16'hACE1; m_prevb = 1'b0;
        end else if (seed_load) begin
            m_state = (seed_val == 16'h0) ? 16'hACE1 : seed_val; m_prevb = 1'b0;
        end else if (en) begin
            m_prevb = m_state[8]; m_state = step(m_state);
        end
    endtask

    function automatic logic [15:0] exp_bits();
        return {14'b0, m_state[0] ^ m_state[8], m_state[0] ^ m_prevb};
    endfunction

    initial begin
        rst = 1'b1; en = 1'b0; seed_load = 1'b0; seed_val = '0;
        m_state = '0; m_prevb = 1'b0;
        tick(); tick();
        chk("R3 reset state", lfsr_q, 16'hACE1);
        chk("R3 reset bits", {14'b0, bits_o}, exp_bits());
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            {en, seed_load, seed_val} = VEC[i];
            tick();
            chk($sformatf("R1/R6/R8 vec %0d state", i), lfsr_q, m_state);
            chk($sformatf("R4/R5 vec %0d bits", i), {14'b0, bits_o}, exp_bits());
        end

        // R7: zero seed gives default, even after running
        en = 1'b1; seed_load = 1'b0; tick(); tick();
        en = 1'b0; seed_load = 1'b1; seed_val = 16'h0000; tick();
        chk("R7 zero seed", lfsr_q, 16'hACE1);
        // R6: bit 0 equals tap A right after load
        chk("R6 fresh first bit", {15'b0, bits_o[0]}, {15'b0, lfsr_q[0]});
        // R8: load wins over enable
        en = 1'b1; seed_load = 1'b1; seed_val = 16'h5A5A; tick();
        chk("R8 load priority", lfsr_q, 16'h5A5A);
        // R5: hold over several clocks
        seed_load = 1'b0; tick();
        en = 1'b0;
        begin
            logic [15:0] s_keep;
            logic [1:0]  b_keep;
            tick(); s_keep = lfsr_q; b_keep = bits_o;
            tick(); tick(); tick();
            chk("R5 hold state", lfsr_q, s_keep);
            chk("R5 hold bits", {14'b0, bits_o}, {14'b0, b_keep});
        end

        // R2: full period from the reset seed
        rst = 1'b1; tick(); rst = 1'b0; en = 1'b1;
        begin
            int n = 0;
            int zeros = 0;
            do begin
                tick(); n++;
                if (lfsr_q == 16'h0) zeros++;
            end while (lfsr_q != 16'hACE1 && n < 70000);
            chk("R2 period", n[15:0], 16'hFFFF);
            chk("R2 period high", {15'b0, n[16]}, 16'h0);
            chk("R2 no zero state", zeros[15:0], 16'h0);
        end
        // R1/R4: one more step checked against the model
        tick();
        chk("R1 step after wrap", lfsr_q, m_state);
        chk("R4 bits after wrap", {14'b0, bits_o}, exp_bits());

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule